// File: doc/BRIEF.md
# Sigma-Delta Two-Stage Decimation Filter

This block converts a one-bit oversampled modulator stream, one bit per clock, into signed 24-bit conversion results. A fixed fifth-order sinc decimator, built from cascaded integrators and combs, reduces the stream by a factor R = 2^DEC_LOG2. A programmable averager follows it. The averager runs as a first-order sinc, which is a plain boxcar sum, or as a second-order sinc, which is a triangular-weighted sum. Its length N = 2^rate_sel sets the output data rate.

A restart pulse clears every filter register. After a restart the front stage discards its unsettled start-up outputs. As a result, in first-order mode the very first result is fully settled. A sticky out-of-range detector marks any result during whose span the range input was seen high. Results are scaled so that the front-stage full scale reaches the 24-bit limits, and they saturate there instead of wrapping.

Top module: `sd_decim`

## Requirements
- R1: Each modulator bit counts as +1 when 1 and -1 when 0. Each front-stage output k (k = 1, 2, ...) is the sum of bits k·R-1 down to k·R-5R+4, counting bits from 0 after a restart. Each bit is weighted by the coefficients of (1+z+...+z^(R-1))^5, and bits before index 0 count as zero.
- R2: The first four front-stage outputs after a reset or restart are discarded. The first first-order result therefore uses front outputs 5 to N+4. In every mode, drdy rises on the second clock edge after the edge that samples the last contributing bit.
- R3: With mode_sel = 0, result c (c = 0, 1, ...) is the sum of N consecutive kept front outputs, starting at kept output c·N. The sum is arithmetically shifted right by rate_sel.
- R4: With mode_sel = 1, the first averager period after a restart gives no result. Result c weights kept front outputs (c+2)·N-1 down to c·N+1 by 1, 2, ..., N, ..., 2, 1. The weighted sum is arithmetically shifted right by 2·rate_sel.
- R5: The averaging length is N = 2^rate_sel, with rate_sel from 0 to 2^RATE_W-1. One result is issued every N·R bits.
- R6: The normalised value is multiplied by 2^(23-5·DEC_LOG2), so the front-stage full scale R^5 maps to 2^23. The result is then clamped to 0x7FFFFF above and 0x800000 below, in two's complement.
- R7: range_flag, issued with a result, is 1 exactly when ovr_in was sampled high on an edge after the previous result's issuing edge (or after the restart edge) and up to and including this result's issuing edge.
- R8: A restart clears all integrator, comb and averager state. Later results are therefore those of a stream starting at the first bit after the restart. drdy is high for exactly one clock per result.
- R9: rate_sel and mode_sel are captured only on a reset or restart edge. Changing them at other times has no effect on results.
- R10: While reset is asserted, result, drdy and range_flag are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock; one bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Synchronous clear of filter state and capture of the configuration |
| mod_bit | input | 1 | Modulator output bit |
| ovr_in | input | 1 | Out-of-range indication from the analog front end |
| rate_sel | input | RATE_W | Averaging length exponent |
| mode_sel | input | 1 | 0 = first-order averager, 1 = second-order averager |
| result | output | OUT_W | Signed conversion result |
| drdy | output | 1 | One-clock strobe for a new result |
| range_flag | output | 1 | Out-of-range mark for the current result |

## Verification
The assertions assume that reset is high from the first edge and that DEC_LOG2 is at least 1, so two results are never issued on adjacent edges. They also assume that nothing other than reset or restart is meant to move the captured configuration. mod_bit, ovr_in, rate_sel and mode_sel are otherwise unconstrained. The stimulus drives random bits, biased-density bits and sparse random range pulses. It also changes the selects between restarts, so every input value the assertions tolerate is reached while the captured configuration stays stable.

// File: rtl/sdd_pkg.sv
package sdd_pkg;
  typedef enum logic {
    AVG_SINC1 = 1'b0,
    AVG_SINC2 = 1'b1
  } avg_mode_e;
endpackage

// File: rtl/sinc5_stage.sv
module sinc5_stage #(
  parameter int L = 3,
  parameter int W = 5 * L + 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                bit_in,
  output logic signed [W-1:0] y,
  output logic                y_valid
);
  localparam int ORD = 5;
  localparam logic signed [W-1:0] FULL = W'(64'sd1 <<< (5 * L));

  logic signed [W-1:0] integ [ORD];
  logic signed [W-1:0] dly   [ORD];
  logic signed [W-1:0] in_n  [ORD];
  logic signed [W-1:0] cm    [ORD];
  logic signed [W-1:0] x;
  logic [L-1:0]        phase;
  logic [2:0]          settle;

  // integrators at the modulator rate (wraparound), combs at the decimated rate
  always_comb begin
    x = bit_in ? {{(W-1){1'b0}}, 1'b1} : {W{1'b1}};
    in_n[0] = integ[0] + x;
    for (int i = 1; i < ORD; i++) in_n[i] = integ[i] + in_n[i-1];
    cm[0] = in_n[ORD-1] - dly[0];
    for (int i = 1; i < ORD; i++) cm[i] = cm[i-1] - dly[i];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < ORD; i++) begin
        integ[i] <= '0;
        dly[i]   <= '0;
      end
      phase   <= '0;
      settle  <= '0;
      y       <= '0;
      y_valid <= 1'b0;
    end else begin
      for (int i = 0; i < ORD; i++) integ[i] <= in_n[i];
      phase   <= phase + 1'b1;
      y_valid <= 1'b0;
      if (phase == {L{1'b1}}) begin
        dly[0] <= in_n[ORD-1];
        for (int i = 1; i < ORD; i++) dly[i] <= cm[i-1];
        if (settle == 3'd4) begin
          y       <= cm[ORD-1];
          y_valid <= 1'b1;
        end else begin
          settle <= settle + 1'b1;
        end
      end
    end
  end

  // R2: nothing leaves the front stage right after a clear
  p_clr_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    clr |=> !y_valid);
  // R1: a settled front output never exceeds full scale
  p_front_range_r1: assert property (@(posedge clk) disable iff (rst)
    y_valid |-> (y <= FULL && y >= -FULL));
endmodule

// File: rtl/avg_stage.sv
module avg_stage
  import sdd_pkg::*;
#(
  parameter int W_IN   = 17,
  parameter int RATE_W = 3,
  parameter int AW     = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic [RATE_W-1:0]     rate,
  input  avg_mode_e             mode,
  input  logic signed [W_IN-1:0] y,
  input  logic                  y_valid,
  output logic signed [AW-1:0]  v,
  output logic                  v_valid
);
  localparam int CW = (1 << RATE_W) - 1;

  logic signed [AW-1:0] a1, a2, d1, d2;
  logic signed [AW-1:0] ye, a1n, a2n, c1, c2;
  logic [CW-1:0]        cnt, lim;
  logic                 primed;

  always_comb begin
    ye  = {{(AW-W_IN){y[W_IN-1]}}, y};
    a1n = a1 + ye;
    a2n = a2 + a1n;
    c1  = ((mode == AVG_SINC1) ? a1n : a2n) - d1;
    c2  = c1 - d2;
    lim = CW'((64'd1 << rate) - 64'd1);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      a1 <= '0; a2 <= '0; d1 <= '0; d2 <= '0;
      cnt <= '0; primed <= 1'b0;
      v <= '0; v_valid <= 1'b0;
    end else begin
      v_valid <= 1'b0;
      if (y_valid) begin
        a1 <= a1n;
        a2 <= a2n;
        if (cnt == lim) begin
          cnt <= '0;
          d1  <= (mode == AVG_SINC1) ? a1n : a2n;
          d2  <= c1;
          if (mode == AVG_SINC1) begin
            v       <= c1 >>> rate;
            v_valid <= 1'b1;
          end else begin
            v       <= c2 >>> {rate, 1'b0};
            v_valid <= primed;
            primed  <= 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R8: a clear empties the averager output
  p_avg_clr_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> !v_valid);
  // R4: a result is only produced when a front sample arrived
  p_avg_needs_input_r4: assert property (@(posedge clk) disable iff (rst)
    (!y_valid || clr) |=> !v_valid);
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int AW   = 32,
  parameter int SHL  = 8,
  parameter int OW   = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic signed [AW-1:0] v,
  input  logic                 v_valid,
  input  logic                 ovr_in,
  output logic [OW-1:0]        result,
  output logic                 drdy,
  output logic                 range_flag
);
  localparam int EW = AW + SHL;
  localparam logic signed [EW-1:0] MAXP = EW'((64'sd1 <<< (OW - 1)) - 64'sd1);
  localparam logic signed [EW-1:0] MINN = EW'(-(64'sd1 <<< (OW - 1)));

  logic signed [EW-1:0] scaled;
  logic [OW-1:0]        clamped;
  logic                 seen;

  always_comb begin
    scaled = EW'(v) <<< SHL;
    if (scaled > MAXP)      clamped = MAXP[OW-1:0];
    else if (scaled < MINN) clamped = MINN[OW-1:0];
    else                    clamped = scaled[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      result     <= '0;
      drdy       <= 1'b0;
      range_flag <= 1'b0;
      seen       <= 1'b0;
    end else begin
      drdy <= v_valid;
      if (v_valid) begin
        result     <= clamped;
        range_flag <= seen | ovr_in;
        seen       <= 1'b0;
      end else begin
        seen <= seen | ovr_in;
      end
    end
  end

  // R8: strobe lasts one clock
  p_drdy_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    drdy |=> !drdy);
  // R7: a range event is never lost
  p_flag_kept_r7: assert property (@(posedge clk) disable iff (rst)
    (ovr_in && !clr) |=> (seen || range_flag));
endmodule

// File: rtl/sd_decim.sv
module sd_decim
  import sdd_pkg::*;
#(
  parameter int DEC_LOG2 = 3,
  parameter int RATE_W   = 3,
  parameter int OUT_W    = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              mod_bit,
  input  logic              ovr_in,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              mode_sel,
  output logic [OUT_W-1:0]  result,
  output logic              drdy,
  output logic              range_flag
);
  localparam int W5    = 5 * DEC_LOG2 + 2;
  localparam int MAXSH = (1 << RATE_W) - 1;
  localparam int AW    = W5 + 2 * MAXSH + 1;
  localparam int SHL   = OUT_W - 1 - 5 * DEC_LOG2;

  logic [RATE_W-1:0]     cfg_rate;
  avg_mode_e             cfg_mode;
  logic signed [W5-1:0]  y;
  logic                  y_valid;
  logic signed [AW-1:0]  v;
  logic                  v_valid;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cfg_rate <= rate_sel;
      cfg_mode <= avg_mode_e'(mode_sel);
    end
  end

  sinc5_stage #(.L(DEC_LOG2), .W(W5)) u_front (
    .clk(clk), .rst(rst), .clr(restart), .bit_in(mod_bit),
    .y(y), .y_valid(y_valid)
  );

  avg_stage #(.W_IN(W5), .RATE_W(RATE_W), .AW(AW)) u_avg (
    .clk(clk), .rst(rst), .clr(restart), .rate(cfg_rate), .mode(cfg_mode),
    .y(y), .y_valid(y_valid), .v(v), .v_valid(v_valid)
  );

  out_stage #(.AW(AW), .SHL(SHL), .OW(OUT_W)) u_out (
    .clk(clk), .rst(rst), .clr(restart), .v(v), .v_valid(v_valid),
    .ovr_in(ovr_in), .result(result), .drdy(drdy), .range_flag(range_flag)
  );

  // R9: configuration moves only on reset or restart
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !restart |=> ($stable(cfg_rate) && $stable(cfg_mode)));
  // R8: no strobe right after a restart
  p_restart_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    restart |=> !drdy);
endmodule

// File: tb/sim_sd_decim.sv
module sim_sd_decim;
  localparam int L   = 3;
  localparam int R   = 1 << L;
  localparam int NW  = 5 * R - 4;
  localparam int SHL = 23 - 5 * L;
  localparam int HMAX = 8192;

  logic clk = 1'b0, rst = 1'b1, restart = 1'b0, mod_bit = 1'b0, ovr_in = 1'b0;
  logic [2:0] rate_sel = 3'd0;
  logic mode_sel = 1'b0;
  logic [23:0] result;
  logic drdy, range_flag;

  int checks = 0, fails = 0;
  longint w [0:NW-1];
  bit hist [0:HMAX-1];
  bit ovr_hist [0:HMAX-1];
  int nb = 0, res_idx = 0, prev_end = -1;
  int m_rate = 0, m_mode = 0;
  bit prev_drdy = 1'b0;
  string vtag = "R3";

  always #2 clk = ~clk;

  sd_decim u0 (
    .clk(clk), .rst(rst), .restart(restart), .mod_bit(mod_bit), .ovr_in(ovr_in),
    .rate_sel(rate_sel), .mode_sel(mode_sel), .result(result), .drdy(drdy),
    .range_flag(range_flag)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint front_out(input int k);
    longint s = 0;
    for (int i = 0; i < NW; i++) begin
      int n = k * R - 1 - i;
      if (n >= 0) s += w[i] * (hist[n] ? 64'sd1 : -64'sd1);
    end
    return s;
  endfunction

  function automatic int needed(input int c);
    int n = 1 << m_rate;
    return (m_mode == 0) ? (4 + (c + 1) * n) * R : (4 + (c + 2) * n) * R;
  endfunction

  function automatic longint expect_val(input int c);
    int n = 1 << m_rate;
    longint s = 0, v;
    if (m_mode == 0) begin
      for (int j = c * n; j < c * n + n; j++) s += front_out(j + 5);
      v = s >>> m_rate;
    end else begin
      int jend = (c + 2) * n - 1;
      for (int t = 0; t <= 2 * n - 2; t++) begin
        longint h = (t + 1 < 2 * n - 1 - t) ? t + 1 : 2 * n - 1 - t;
        s += h * front_out(jend - t + 5);
      end
      v = s >>> (2 * m_rate);
    end
    v = v * (64'sd1 <<< SHL);
    if (v > 64'sd8388607) v = 64'sd8388607;
    if (v < -64'sd8388608) v = -64'sd8388608;
    return v;
  endfunction

  task automatic sample_out();
    if (drdy) begin
      longint e = expect_val(res_idx);
      int nd = needed(res_idx);
      bit ef = 1'b0;
      for (int i = prev_end + 1; i <= nd + 1; i++) if (i < HMAX && i >= 0) ef |= ovr_hist[i];
      check(longint'($signed(result)) == e, vtag, longint'($signed(result)), e);
      check(nb == nd + 2, "R2", nb, nd + 2);
      check(range_flag == ef, "R7", range_flag, ef);
      check(!prev_drdy, "R8", prev_drdy, 0);
      prev_end = nd + 1;
      res_idx++;
    end
    prev_drdy = drdy;
  endtask

  task automatic do_restart(input int rt, input int md);
    @(negedge clk);
    sample_out();
    rate_sel = 3'(rt); mode_sel = md[0]; restart = 1'b1; ovr_in = 1'b0;
    m_rate = rt; m_mode = md;
    nb = 0; res_idx = 0; prev_end = -1;
    @(negedge clk);
    restart = 1'b0;
    prev_drdy = 1'b0;
    check(drdy == 1'b0, "R8", drdy, 0);
  endtask

  // kind: 0 zeros, 1 ones, 2 random, 3 biased density; first drive done at the current negedge
  task automatic run_res(input int nres, input int kind, input bit ovr_rand);
    int target = res_idx + nres;
    bit first = 1'b1;
    while (res_idx < target) begin
      bit b;
      if (!first) begin
        @(negedge clk);
        sample_out();
      end
      first = 1'b0;
      case (kind)
        0: b = 1'b0;
        1: b = 1'b1;
        2: b = 1'($urandom);
        default: b = (($urandom % 100) < 78);
      endcase
      mod_bit = b;
      ovr_in = ovr_rand && (($urandom % 150) == 0);
      if (nb < HMAX) begin
        hist[nb] = b;
        ovr_hist[nb] = ovr_in;
      end
      nb++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    longint tmp [0:NW-1];
    int len = 1;
    void'($urandom(32'd2024));
    for (int i = 0; i < NW; i++) w[i] = 0;
    w[0] = 1;
    for (int s = 0; s < 5; s++) begin
      for (int i = 0; i < NW; i++) begin
        tmp[i] = 0;
        for (int m = 0; m < R; m++) if (i - m >= 0) tmp[i] += w[i - m];
      end
      len += R - 1;
      for (int i = 0; i < NW; i++) w[i] = (i < len) ? tmp[i] : 0;
    end

    // R10 reset state
    repeat (4) @(negedge clk);
    check(drdy == 1'b0, "R10", drdy, 0);
    check(result == 24'd0, "R10", result, 0);
    check(range_flag == 1'b0, "R10", range_flag, 0);
    @(negedge clk);
    rst = 1'b0;

    // R6 saturation both ways
    vtag = "R6"; do_restart(0, 0); run_res(4, 1, 1'b0);
    vtag = "R6"; do_restart(3, 0); run_res(3, 0, 1'b0);
    // R1 raw front stage (N = 1), random bits
    vtag = "R1"; do_restart(0, 0); run_res(20, 2, 1'b1);
    // R3 first-order averaging
    vtag = "R3"; do_restart(2, 0); run_res(8, 3, 1'b1);
    // R4 second-order averaging
    vtag = "R4"; do_restart(1, 1); run_res(8, 2, 1'b1);
    vtag = "R4"; do_restart(4, 1); run_res(4, 3, 1'b1);
    // R5 longest averaging length in both modes
    vtag = "R5"; do_restart(7, 0); run_res(2, 2, 1'b1);
    vtag = "R5"; do_restart(7, 1); run_res(2, 3, 1'b1);
    // R9 select changes between restarts have no effect
    vtag = "R9"; do_restart(2, 0);
    rate_sel = 3'd5; mode_sel = 1'b1;
    run_res(5, 2, 1'b1);
    // R8 restart in the middle of a conversion
    vtag = "R8"; do_restart(1, 1); run_res(1, 2, 1'b1);
    repeat (11) begin
      @(negedge clk);
      sample_out();
      mod_bit = 1'($urandom);
    end
    do_restart(1, 1); run_res(4, 2, 1'b1);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule